// File: doc/BRIEF.md
# Serial Avionics Word Transmitter

This block sends words from a host onto a two-wire, return-to-zero serial bus of the kind used for avionics data links. The host writes whole words into an eight-entry buffer. While the enable input is low nothing new goes out, so the host can stage a block of one to eight words. Raising the enable starts the transmitter, which sends the buffered words in the order they were written. The bit rate comes from a clock-enable pulse, `half_tick`, and each pulse marks half a bit period. The two output legs are TTL-level signals meant for an external line driver.

A small control register selects the word format. The long format is 32 bits and the short format is 25 bits. Parity is odd or even. A spare data bit can take the place of parity. The control register is sampled at the moment a word starts, so one word never mixes settings. After each word the transmitter holds both legs low for four bit-times. This null gap is always served in full, even when new words are loaded and enabled while it is still running. A ready flag tells the host when the buffer is drained and no word is on the wire. A full flag tells the host that further writes will be dropped.

Top module: `awtx_top`

## Requirements
- R1: Master reset (`rst_n` low, asynchronous) drives both legs low, sets `ready` to 1 and `full` to 0, and clears the control register. A word sent after reset, with no control write, uses the 32-bit format with odd parity.
- R2: Each bit lasts two `half_tick` pulses. In the first half, `line_hi` is high for a 1 or `line_lo` is high for a 0. In the second half, both legs are low. The two legs are never high together.
- R3: A word starts with its label, word bits 7 down to 0 (most significant first). It continues with word bits 8 upward (least significant first).
- R4: In the 32-bit format (`cfg_in[0]`=0), 32 bits are sent. The last bit is a parity bit over word bits 30..0, odd by default, so that the 32 sent bits hold an odd number of ones.
- R5: In the 25-bit format (`cfg_in[0]`=1), 25 bits are sent: the label, data bits 23..8, and a last parity bit over word bits 23..0.
- R6: With `cfg_in[1]`=1, the parity bit makes the total count of ones even instead of odd.
- R7: With `cfg_in[2]`=1, the last bit is not parity. It is the host's own word bit 31 in the 32-bit format, or word bit 24 in the 25-bit format.
- R8: After every word, both legs stay low for exactly 4 bit-times (8 pulses). If another word is waiting and enabled, it starts on the next pulse, so a word occupies 36 or 29 bit-times.
- R9: A word that is written and enabled while a gap is running still waits for the full gap to end.
- R10: While `tx_en` is low, no new word starts. Once it is high, the buffered words are sent in the order they were written.
- R11: The buffer holds 8 words. `full` is 1 while 8 are held. A write to a full buffer is ignored and its word is never sent.
- R12: `ready` is 1 exactly when the buffer is empty and no word is being shifted out. It is 0 while the last word of a block is still on the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset, asynchronous |
| half_tick | input | 1 | Clock enable, one pulse per half bit period |
| cfg_wr | input | 1 | Loads `cfg_in` into the control register |
| cfg_in | input | 3 | bit0 short format, bit1 even parity, bit2 spare data bit in place of parity |
| wr_en | input | 1 | Writes `wr_word` into the buffer |
| wr_word | input | 32 | Word to buffer; label in bits 7..0 |
| tx_en | input | 1 | Allows buffered words to start |
| ready | output | 1 | Buffer empty and transmitter not sending |
| full | output | 1 | Buffer holds 8 words |
| line_hi | output | 1 | Leg pulsed high for a 1 bit |
| line_lo | output | 1 | Leg pulsed high for a 0 bit |

## Verification
The hardest case to reach from the ports is a word arriving in the middle of an inter-word gap. To get there, the bench lets one word finish with the enable already high and counts three gap pulses. Only then does it write the next word, and it expects five more null pulses before the first bit appears. The bench checks format and order against a bit-by-bit reference built from the requirements. It also pushes the buffer past full to confirm that the ninth word never reaches the wire, and it resets in the middle of a word to confirm that the control register falls back to its default.

// File: rtl/awtx_pkg.sv
package awtx_pkg;

    // Control register; packed so that cfg_in[0] maps to short_fmt
    typedef struct packed {
        logic spare_bit;
        logic even_par;
        logic short_fmt;
    } awtx_cfg_t;

    typedef enum logic {
        ST_REST = 1'b0,
        ST_SEND = 1'b1
    } awtx_state_e;

endpackage

// File: rtl/awtx_fifo.sv
module awtx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t fs_d, fs_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        fs_d    = fs_q;
        do_push = push && (fs_q.cnt != CW'(DEPTH));
        do_pop  = pop && (fs_q.cnt != '0);
        if (do_push) begin
            fs_d.wp = (fs_q.wp == PW'(DEPTH - 1)) ? '0 : fs_q.wp + PW'(1);
        end
        if (do_pop) begin
            fs_d.rp = (fs_q.rp == PW'(DEPTH - 1)) ? '0 : fs_q.rp + PW'(1);
        end
        fs_d.cnt = fs_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[fs_q.wp] <= din;
        end
    end

    assign dout  = mem_q[fs_q.rp];
    assign empty = (fs_q.cnt == '0);
    assign full  = (fs_q.cnt == CW'(DEPTH));

    // R11: a write into a full buffer without a read leaves the count unchanged
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (fs_q.cnt == CW'(DEPTH)));

    // R11: the count never exceeds the depth
    p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fs_q.cnt <= CW'(DEPTH));

endmodule

// File: rtl/awtx_framer.sv
module awtx_framer
    import awtx_pkg::*;
#(
    parameter int LONG_BITS  = 32,
    parameter int SHORT_BITS = 25,
    parameter int LABEL_BITS = 8,
    localparam int NW        = $clog2(LONG_BITS + 1)
) (
    input  logic [LONG_BITS-1:0] word,
    input  awtx_cfg_t            cfg,
    output logic [LONG_BITS-1:0] seq,
    output logic [NW-1:0]        nbits
);
    localparam logic [LONG_BITS-1:0] SHORT_MASK =
        {{(LONG_BITS - SHORT_BITS){1'b0}}, {SHORT_BITS{1'b1}}};

    logic [LONG_BITS-1:0] body;
    logic                 data_x;
    logic                 last_bit;
    logic                 pbit;

    // seq[i] is the i-th bit on the wire: reversed label, then the rest ascending
    for (genvar i = 0; i < LONG_BITS; i++) begin : g_pos
        if (i < LABEL_BITS) begin : g_label
            assign body[i] = word[LABEL_BITS-1-i];
        end else begin : g_data
            assign body[i] = word[i];
        end
    end

    always_comb begin
        data_x   = cfg.short_fmt ? ^word[SHORT_BITS-2:0] : ^word[LONG_BITS-2:0];
        last_bit = cfg.short_fmt ? word[SHORT_BITS-1] : word[LONG_BITS-1];
        if (cfg.spare_bit) begin
            pbit = last_bit;
        end else if (cfg.even_par) begin
            pbit = data_x;
        end else begin
            pbit = ~data_x;
        end

        if (cfg.short_fmt) begin
            seq                 = body & SHORT_MASK;
            seq[SHORT_BITS-1]   = pbit;
            nbits               = NW'(SHORT_BITS);
        end else begin
            seq                 = body;
            seq[LONG_BITS-1]    = pbit;
            nbits               = NW'(LONG_BITS);
        end
    end

endmodule

// File: rtl/awtx_serializer.sv
module awtx_serializer
    import awtx_pkg::*;
#(
    parameter int LONG_BITS = 32,
    parameter int GAP_BITS  = 4,
    localparam int NW       = $clog2(LONG_BITS + 1),
    localparam int GW       = $clog2(2 * GAP_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 half_tick,
    input  logic                 tx_en,
    input  logic                 avail,
    input  logic [LONG_BITS-1:0] seq,
    input  logic [NW-1:0]        nbits,
    output logic                 pop,
    output logic                 sending,
    output logic                 line_hi,
    output logic                 line_lo
);
    typedef struct packed {
        awtx_state_e          state;
        logic [LONG_BITS-1:0] shreg;
        logic [NW-1:0]        left;
        logic                 phase;
        logic [GW-1:0]        gap;
        logic                 hi;
        logic                 lo;
    } ser_st_t;

    ser_st_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        pop  = 1'b0;
        if (half_tick) begin
            case (sr_q.state)
                ST_REST: begin
                    sr_d.hi = 1'b0;
                    sr_d.lo = 1'b0;
                    if (sr_q.gap != '0) begin
                        sr_d.gap = sr_q.gap - GW'(1);
                    end else if (tx_en && avail) begin
                        pop        = 1'b1;
                        sr_d.state = ST_SEND;
                        sr_d.shreg = seq;
                        sr_d.left  = nbits;
                        sr_d.hi    = seq[0];
                        sr_d.lo    = ~seq[0];
                        sr_d.phase = 1'b1;
                    end
                end
                default: begin
                    if (sr_q.phase) begin
                        sr_d.hi    = 1'b0;
                        sr_d.lo    = 1'b0;
                        sr_d.phase = 1'b0;
                        sr_d.shreg = sr_q.shreg >> 1;
                        sr_d.left  = sr_q.left - NW'(1);
                        if (sr_q.left == NW'(1)) begin
                            sr_d.state = ST_REST;
                            sr_d.gap   = GW'(2 * GAP_BITS);
                        end
                    end else begin
                        sr_d.hi    = sr_q.shreg[0];
                        sr_d.lo    = ~sr_q.shreg[0];
                        sr_d.phase = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign sending = (sr_q.state == ST_SEND);
    assign line_hi = sr_q.hi;
    assign line_lo = sr_q.lo;

    // R2: the two legs are never driven high together
    p_legs_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo));

    // R2: in the first half of a bit exactly one leg is high
    p_first_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && sr_q.phase) |-> $onehot({line_hi, line_lo}));

    // R2: in the second half of a bit both legs are low
    p_second_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && !sr_q.phase) |-> (!line_hi && !line_lo));

    // R8: between words the line carries nulls only
    p_rest_null_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sending |-> (!line_hi && !line_lo));

    // R9: a running gap is never cut short by a waiting word
    p_gap_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sending && sr_q.gap != '0) |=> !sending);

    // R10: with the enable low no word begins
    p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sending && !tx_en) |=> !sending);

endmodule

// File: rtl/awtx_top.sv
module awtx_top
    import awtx_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int LONG_BITS  = 32,
    parameter int SHORT_BITS = 25,
    parameter int LABEL_BITS = 8,
    parameter int GAP_BITS   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 half_tick,
    input  logic                 cfg_wr,
    input  logic [2:0]           cfg_in,
    input  logic                 wr_en,
    input  logic [LONG_BITS-1:0] wr_word,
    input  logic                 tx_en,
    output logic                 ready,
    output logic                 full,
    output logic                 line_hi,
    output logic                 line_lo
);
    localparam int NW = $clog2(LONG_BITS + 1);

    awtx_cfg_t cfg_d, cfg_q;

    logic [LONG_BITS-1:0] head_word;
    logic [LONG_BITS-1:0] seq;
    logic [NW-1:0]        nbits;
    logic                 empty;
    logic                 pop;
    logic                 sending;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d = awtx_cfg_t'(cfg_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    awtx_fifo #(
        .WIDTH (LONG_BITS),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .din   (wr_word),
        .pop   (pop),
        .dout  (head_word),
        .empty (empty),
        .full  (full)
    );

    awtx_framer #(
        .LONG_BITS  (LONG_BITS),
        .SHORT_BITS (SHORT_BITS),
        .LABEL_BITS (LABEL_BITS)
    ) u_framer (
        .word  (head_word),
        .cfg   (cfg_q),
        .seq   (seq),
        .nbits (nbits)
    );

    awtx_serializer #(
        .LONG_BITS (LONG_BITS),
        .GAP_BITS  (GAP_BITS)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .tx_en     (tx_en),
        .avail     (!empty),
        .seq       (seq),
        .nbits     (nbits),
        .pop       (pop),
        .sending   (sending),
        .line_hi   (line_hi),
        .line_lo   (line_lo)
    );

    assign ready = empty && !sending;

    // R12: while a word is on the wire the block is not ready
    p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (line_hi || line_lo) |-> !ready);

endmodule

// File: tb/awtx_top_bench.sv
module awtx_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_tick = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_in = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic        tx_en = 1'b0;
    logic        ready, full, line_hi, line_lo;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    awtx_top u_awtx_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .cfg_wr    (cfg_wr),
        .cfg_in    (cfg_in),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .tx_en     (tx_en),
        .ready     (ready),
        .full      (full),
        .line_hi   (line_hi),
        .line_lo   (line_lo)
    );

    // stimulus table: {cfg[2:0], word[31:0]}
    localparam logic [34:0] VEC [6] = '{
        {3'b000, 32'h6A5C_3E81},
        {3'b001, 32'h00F1_23C4},
        {3'b010, 32'h1234_56F7},
        {3'b011, 32'h0100_A55A},
        {3'b100, 32'h8000_0F0F},
        {3'b101, 32'h0100_0033}
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // reference: bit k of the result is the k-th bit sent on the wire
    function automatic logic [31:0] ref_frame(input logic [31:0] w, input logic [2:0] c);
        logic [31:0] r = '0;
        int len = c[0] ? 25 : 32;
        int idx = 0;
        int ones = 0;
        for (int i = 7; i >= 0; i--) begin
            r[idx] = w[i];
            idx++;
        end
        for (int b = 8; b <= len - 2; b++) begin
            r[idx] = w[b];
            idx++;
        end
        for (int b = 0; b <= len - 2; b++) ones += int'(w[b]);
        if (c[2]) r[idx] = w[len-1];
        else if (c[1]) r[idx] = (ones % 2 == 1);
        else r[idx] = (ones % 2 == 0);
        return r;
    endfunction

    task automatic tick();
        @(negedge clk) half_tick = 1'b1;
        @(negedge clk) half_tick = 1'b0;
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk) begin wr_en = 1'b1; wr_word = w; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic set_cfg(input logic [2:0] c);
        @(negedge clk) begin cfg_wr = 1'b1; cfg_in = c; end
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    task automatic recv_word(input logic [31:0] w, input logic [2:0] c, input string tag,
                             output logic rdy_first);
        logic [31:0] got = '0;
        logic [31:0] exp = ref_frame(w, c);
        logic shape_ok = 1'b1;
        int len = c[0] ? 25 : 32;
        rdy_first = 1'b0;
        for (int k = 0; k < len; k++) begin
            tick();
            if (k == 0) rdy_first = ready;
            got[k] = line_hi;
            if (line_hi == line_lo) shape_ok = 1'b0;
            tick();
            if (line_hi || line_lo) shape_ok = 1'b0;
        end
        check(shape_ok && (got == exp), tag, got, exp);
    endtask

    task automatic expect_null(input int count, input string tag);
        logic quiet = 1'b1;
        for (int k = 0; k < count; k++) begin
            tick();
            if (line_hi || line_lo) quiet = 1'b0;
        end
        check(quiet, tag, {30'd0, line_hi, line_lo}, 32'd0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic rdy;
        logic [31:0] blk [9];

        repeat (4) @(negedge clk);
        check(!line_hi && !line_lo, "R1 legs low in reset", {30'd0, line_hi, line_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R1 ready after reset", {31'd0, ready}, 1);
        check(full == 1'b0, "R1 full after reset", {31'd0, full}, 0);

        // R1: default control -> 32-bit odd parity, no cfg write yet
        push(32'h0F0F_00C3);
        tx_en = 1'b1;
        recv_word(32'h0F0F_00C3, 3'b000, "R1 R4 default format", rdy);
        expect_null(8, "R8 gap after default word");

        // table: formats, ordering, parity modes (R3 R4 R5 R6 R7)
        foreach (VEC[i]) begin
            set_cfg(VEC[i][34:32]);
            push(VEC[i][31:0]);
            recv_word(VEC[i][31:0], VEC[i][34:32], "R3 R4 R5 R6 R7 table vector", rdy);
            expect_null(8, "R8 gap after table word");
        end

        // R10 hold-off and order, R8 back-to-back timing (long format)
        set_cfg(3'b000);
        tx_en = 1'b0;
        push(32'hAAAA_0001);
        push(32'h5555_0002);
        push(32'h0000_0003);
        expect_null(20, "R10 held while disabled");
        check(ready == 1'b0, "R12 not ready with words buffered", {31'd0, ready}, 0);
        tx_en = 1'b1;
        recv_word(32'hAAAA_0001, 3'b000, "R10 first of block", rdy);
        expect_null(8, "R8 gap 36 bit-times");
        recv_word(32'h5555_0002, 3'b000, "R8 R10 second starts right after gap", rdy);
        expect_null(8, "R8 gap");
        recv_word(32'h0000_0003, 3'b000, "R8 R10 third in order", rdy);
        expect_null(8, "R8 gap");

        // R8 short format back to back: 29 bit-times per word
        set_cfg(3'b001);
        tx_en = 1'b0;
        push(32'h00AB_CD12);
        push(32'h0155_AA34);
        tx_en = 1'b1;
        recv_word(32'h00AB_CD12, 3'b001, "R5 R8 short first", rdy);
        expect_null(8, "R8 short gap");
        recv_word(32'h0155_AA34, 3'b001, "R5 R8 short follows after 4 null bits", rdy);
        expect_null(8, "R8 short gap");

        // R9: word written mid-gap waits for full gap
        set_cfg(3'b000);
        push(32'hC0DE_0011);
        recv_word(32'hC0DE_0011, 3'b000, "R9 lead word", rdy);
        expect_null(3, "R9 first part of gap");
        push(32'hBEEF_0022);
        expect_null(5, "R9 gap completed after mid-gap load");
        recv_word(32'hBEEF_0022, 3'b000, "R9 word after full gap", rdy);
        expect_null(8, "R9 trailing gap");

        // R11: fill, overfill, drain; R12 ready behaviour
        tx_en = 1'b0;
        for (int i = 0; i < 9; i++) blk[i] = 32'h1000_0000 + (32'h0101_0101 * i) + 32'h40;
        for (int i = 0; i < 8; i++) push(blk[i]);
        @(negedge clk);
        check(full == 1'b1, "R11 full after eight writes", {31'd0, full}, 1);
        push(blk[8]);
        check(full == 1'b1, "R11 still full after ignored write", {31'd0, full}, 1);
        tx_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            recv_word(blk[i], 3'b000, "R11 buffered word drained in order", rdy);
            if (i == 7) check(rdy == 1'b0, "R12 not ready while last word sends",
                              {31'd0, rdy}, 0);
            if (i == 0) check(full == 1'b0, "R11 full clears after a send",
                              {31'd0, full}, 0);
            expect_null(8, "R8 gap while draining");
        end
        expect_null(16, "R11 ninth write never sent");
        check(ready == 1'b1, "R12 ready after block", {31'd0, ready}, 1);

        // R1: reset mid-word clears outputs and control register
        set_cfg(3'b011);
        push(32'h7777_0044);
        tick();
        tick();
        tick();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check(!line_hi && !line_lo, "R1 legs low on mid-word reset",
              {30'd0, line_hi, line_lo}, 0);
        check(ready == 1'b1, "R1 ready after mid-word reset", {31'd0, ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        push(32'h7777_0044);
        recv_word(32'h7777_0044, 3'b000, "R1 control cleared by reset", rdy);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule